// File: doc/BRIEF.md
# Charge-Pump Lock Detector

This block watches the up and down pulses that a phase/frequency comparator sends to its charge pump and decides whether the synthesizer loop is in lock. It runs on the crystal clock, so a pump pulse is measured as the number of consecutive crystal cycles in which either pump signal is high. Any pulse that outlasts the narrow-pulse limit counts as a wide pulse. A wide pulse drops the lock flag on the next clock edge.

The flag is raised again only at a reference-period strobe. It is raised once enough consecutive reference periods have passed without a wide pulse. A period with no pump activity at all counts as clean. The period in which a wide pulse happened never counts toward the run. After a loss of lock the flag therefore returns between LOCK_PERIODS and LOCK_PERIODS+1 strobes later, depending on where the wide pulse fell in its period. A controller reads the flag to know when the tuned frequency has settled.

Top module: `lockdet_top`

## Requirements
- R1: While reset is asserted and on the first edges after it is released, `lock_flag` is 0 and the run of clean periods starts empty.
- R2: When `pump_up`, `pump_dn` or both together have been high for MAX_NARROW_CYC+1 consecutive clock cycles, `lock_flag` is 0 after that edge. The default MAX_NARROW_CYC is 1, so a 2-cycle pulse is wide.
- R3: A pulse of at most MAX_NARROW_CYC cycles neither clears `lock_flag` nor breaks the run of clean periods.
- R4: `lock_flag` rises only on an edge at which `ref_tick` is 1, and only when that strobe closes the LOCK_PERIODS-th consecutive clean period. The default LOCK_PERIODS is 8. After reset, the flag is 0 after 7 strobes and 1 after the 8th.
- R5: A reference period that contains a wide pulse, including one detected in the same cycle as its closing strobe, is not counted, and a wide pulse empties the run. A wide pulse that falls between strobes therefore needs LOCK_PERIODS+1 further strobes for the flag to return. A wide pulse that coincides with a strobe needs LOCK_PERIODS further strobes.
- R6: A reference period with no pump activity counts as clean.
- R7: The width measurement saturates. A pump held high for hundreds of cycles keeps `lock_flag` at 0 throughout, and relocking afterwards follows R5.
- R8: Up and down activity in back-to-back cycles forms one pulse. One cycle of `pump_up` followed at once by one cycle of `pump_dn` is a 2-cycle wide pulse.
- R9: Once set, `lock_flag` stays 1 across clean strobes and narrow pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; pulse widths are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| pump_up | input | 1 | Up pulse from the phase comparator |
| pump_dn | input | 1 | Down pulse from the phase comparator |
| ref_tick | input | 1 | One-cycle strobe at the end of each reference period |
| lock_flag | output | 1 | 1 while the loop is judged locked |

## Verification
The bench aims at the boundary between narrow and wide pulses. A design that measures width off by one would either drop lock on a legal one-cycle pulse or keep lock through a two-cycle pulse. The bench counts strobes precisely during relock. A design that counts the dirty period, or ignores a wide pulse that meets a strobe in the same cycle, would raise the flag one strobe early. The bench also joins an up cycle to a down cycle, and it holds the pump high far beyond the counter range. A design that treats the two pump lines separately would miss that wide pulse. A design whose width counter wraps would mistake the long pulse for a narrow one and misjudge the relock.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    // Default narrow-pulse limit, in crystal cycles.
    localparam int unsigned DEF_MAX_NARROW_CYC = 1;
    // Default number of consecutive clean reference periods needed for lock.
    localparam int unsigned DEF_LOCK_PERIODS   = 8;

    // Verdict on a reference period at the strobe that closes it.
    typedef enum logic {
        PERIOD_CLEAN = 1'b0,
        PERIOD_DIRTY = 1'b1
    } period_verdict_e;

endpackage

// File: rtl/lockdet_width_meter.sv
module lockdet_width_meter #(
    parameter int unsigned MAX_NARROW_CYC = lockdet_pkg::DEF_MAX_NARROW_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_up,
    input  logic pump_dn,
    output logic wide_now
);
    localparam int unsigned SAT = MAX_NARROW_CYC + 1;
    localparam int unsigned CW  = $clog2(SAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wm_state_t;

    wm_state_t st_d, st_q;
    logic      pump_act;

    always_comb begin
        pump_act = pump_up | pump_dn;
        st_d     = st_q;
        if (!pump_act) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(SAT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // This cycle is the (MAX_NARROW_CYC+1)-th or later of the pulse.
        wide_now = pump_act && (st_q.cnt >= CW'(MAX_NARROW_CYC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lockdet_run_tracker.sv
module lockdet_run_tracker #(
    parameter int unsigned LOCK_PERIODS = lockdet_pkg::DEF_LOCK_PERIODS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wide_now,
    input  logic ref_tick,
    output logic locked
);
    import lockdet_pkg::*;

    localparam int unsigned RW = $clog2(LOCK_PERIODS + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(LOCK_PERIODS);
    localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_PERIODS - 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          dirty;
        logic          locked;
    } rt_state_t;

    rt_state_t       st_d, st_q;
    period_verdict_e verdict;

    always_comb begin
        st_d    = st_q;
        verdict = (st_q.dirty || wide_now) ? PERIOD_DIRTY : PERIOD_CLEAN;

        if (wide_now) begin
            st_d.run    = '0;
            st_d.locked = 1'b0;
        end

        if (ref_tick) begin
            st_d.dirty = 1'b0;
            if (verdict == PERIOD_CLEAN) begin
                if (st_q.run != RUN_FULL) begin
                    st_d.run = st_q.run + 1'b1;
                end
                if (st_q.run >= RUN_LAST) begin
                    st_d.locked = 1'b1;
                end
            end
        end else if (wide_now) begin
            st_d.dirty = 1'b1;
        end

        locked = st_q.locked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top #(
    parameter int unsigned MAX_NARROW_CYC = lockdet_pkg::DEF_MAX_NARROW_CYC,
    parameter int unsigned LOCK_PERIODS   = lockdet_pkg::DEF_LOCK_PERIODS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_up,
    input  logic pump_dn,
    input  logic ref_tick,
    output logic lock_flag
);
    logic wide_now;

    lockdet_width_meter #(
        .MAX_NARROW_CYC(MAX_NARROW_CYC)
    ) meter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pump_up (pump_up),
        .pump_dn (pump_dn),
        .wide_now(wide_now)
    );

    lockdet_run_tracker #(
        .LOCK_PERIODS(LOCK_PERIODS)
    ) tracker_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_now(wide_now),
        .ref_tick(ref_tick),
        .locked  (lock_flag)
    );

endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
    parameter int unsigned MAX_NARROW_CYC = lockdet_pkg::DEF_MAX_NARROW_CYC
) (
    input logic clk,
    input logic rst_n,
    input logic pump_up,
    input logic pump_dn,
    input logic ref_tick,
    input logic lock_flag
);
    localparam int unsigned KW = $clog2(MAX_NARROW_CYC + 1) + 1;

    // Independent run-length of pump activity, saturating at the limit.
    logic [KW-1:0] act_cnt_q;
    logic          pump_act;
    logic          wide_seen;

    assign pump_act  = pump_up | pump_dn;
    assign wide_seen = pump_act && (act_cnt_q >= KW'(MAX_NARROW_CYC));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt_q <= '0;
        end else if (!pump_act) begin
            act_cnt_q <= '0;
        end else if (act_cnt_q < KW'(MAX_NARROW_CYC)) begin
            act_cnt_q <= act_cnt_q + 1'b1;
        end
    end

    // R2 / R8: a pulse reaching the wide length clears the flag next cycle.
    a_r2_wide_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wide_seen |=> !lock_flag);

    // R4: the flag rises only on a reference strobe.
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(ref_tick));

    // R5: the strobe that raises the flag cannot coincide with a wide pulse.
    a_r5_rise_clean_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(!wide_seen));

    // R9: the flag falls only while the pump is active.
    a_r9_fall_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_flag) |-> $past(pump_act));

    // R1: the flag is a known value outside reset.
    a_r1_flag_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(lock_flag));

endmodule

bind lockdet_top lockdet_checker #(
    .MAX_NARROW_CYC(MAX_NARROW_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .ref_tick (ref_tick),
    .lock_flag(lock_flag)
);

// File: tb/lockdet_top_tb.sv
`timescale 1ns/1ps
module lockdet_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pump_up = 1'b0;
    logic pump_dn = 1'b0;
    logic ref_tick = 1'b0;
    logic lock_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lockdet_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .ref_tick (ref_tick),
        .lock_flag(lock_flag)
    );

    task automatic check(input logic exp, input string tag);
        n_vec++;
        if (lock_flag !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_flag=%b expected=%b at %0t", tag, lock_flag, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One reference strobe; flag is updated when this returns.
    task automatic tick();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
        idle(2);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Pump pulse of len cycles on the chosen line(s).
    task automatic pulse(input logic up, input logic dn, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pump_up = up;
            pump_dn = dn;
        end
        @(negedge clk);
        pump_up = 1'b0;
        pump_dn = 1'b0;
        idle(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pump_up = 1'b0; pump_dn = 1'b0; ref_tick = 1'b0;
        idle(3);
        check(1'b0, "R1 flag low in reset");
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check(1'b0, "R1 flag low after reset");
    endtask

    task automatic t_lock_from_reset();
        ticks(7);
        check(1'b0, "R4 not locked after 7 clean strobes");
        tick();
        check(1'b1, "R4/R6 locked after 8th clean strobe");
    endtask

    task automatic t_narrow_keeps_lock();
        pulse(1'b1, 1'b0, 1);
        check(1'b1, "R3 one-cycle up pulse keeps lock");
        pulse(1'b0, 1'b1, 1);
        check(1'b1, "R3 one-cycle down pulse keeps lock");
        ticks(3);
        check(1'b1, "R9 lock held over clean strobes");
    endtask

    task automatic t_wide_up_relock();
        pulse(1'b1, 1'b0, 2);
        check(1'b0, "R2 two-cycle up pulse clears lock");
        ticks(8);
        check(1'b0, "R5 dirty period not counted after 8 strobes");
        tick();
        check(1'b1, "R5 relock on 9th strobe");
    endtask

    task automatic t_wide_dn();
        pulse(1'b0, 1'b1, 2);
        check(1'b0, "R2 two-cycle down pulse clears lock");
        ticks(9);
        check(1'b1, "R2 relock after down pulse");
    endtask

    task automatic t_wide_with_tick();
        @(negedge clk) pump_up = 1'b1;
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) begin pump_up = 1'b0; ref_tick = 1'b0; end
        idle(2);
        check(1'b0, "R5 wide pulse on strobe clears lock");
        ticks(7);
        check(1'b0, "R5 strobe-aligned wide: 7 strobes not enough");
        tick();
        check(1'b1, "R5 strobe-aligned wide: relock on 8th");
    endtask

    task automatic t_narrow_in_run();
        pulse(1'b1, 1'b0, 2);
        tick();
        ticks(4);
        pulse(1'b0, 1'b1, 1);
        ticks(3);
        check(1'b0, "R3 run still short");
        tick();
        check(1'b1, "R3 narrow pulse did not break run");
    endtask

    task automatic t_wide_mid_run();
        pulse(1'b1, 1'b0, 2);
        tick();
        ticks(5);
        pulse(1'b1, 1'b0, 3);
        check(1'b0, "R5 flag still low after second wide");
        tick();
        ticks(7);
        check(1'b0, "R5 run emptied by wide pulse");
        tick();
        check(1'b1, "R5 relock after restarted run");
    endtask

    task automatic t_overlap();
        @(negedge clk) pump_up = 1'b1;
        @(negedge clk) begin pump_up = 1'b0; pump_dn = 1'b1; end
        @(negedge clk) pump_dn = 1'b0;
        idle(2);
        check(1'b0, "R8 back-to-back up then down is wide");
        ticks(9);
        check(1'b1, "R8 relock after joined pulse");
    endtask

    task automatic t_long_pulse();
        @(negedge clk) pump_up = 1'b1;
        idle(150);
        check(1'b0, "R7 flag low mid long pulse");
        pump_dn = 1'b1;
        idle(150);
        check(1'b0, "R7 flag low late in long pulse");
        pump_up = 1'b0; pump_dn = 1'b0;
        idle(2);
        ticks(8);
        check(1'b0, "R7 no early relock after long pulse");
        tick();
        check(1'b1, "R7 relock after long pulse");
    endtask

    initial begin
        do_reset();
        t_lock_from_reset();
        t_narrow_keeps_lock();
        t_wide_up_relock();
        t_wide_dn();
        t_wide_with_tick();
        t_narrow_in_run();
        t_wide_mid_run();
        t_overlap();
        t_long_pulse();
        do_reset();
        t_lock_from_reset();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule